// File: doc/BRIEF.md
# Pattern-Based Symbol Aligner

The aligner sits on the receive path right after a deserializer and finds where symbols begin in a raw word stream that can be offset by any number of bits. It joins each incoming word with the one before it into a double-width window. It then tests every bit offset of that window in parallel against a programmable alignment word. The test uses a per-bit mask and can also accept the inverse of the word. As an option, the aligner also requires a trailing sequence word in the next word at the same offset.

A search is started only by a rising edge on a trigger input. A lock counter must reach its threshold with hits at one offset before alignment is declared. Once locked, the offset is frozen. Loss of alignment is then tracked by an unlock tally that counts bad symbols and an unlock-decrement counter that forgives bad symbols over runs of good ones. A mode input chooses what counts as bad: misalignment, a decode error, or a decode or disparity error. The output is the stream re-sliced at the chosen offset.

Top module: `symbol_aligner`

## Requirements
- R1: After reset `locked` is 0, `offset` is 0 and `out_valid` is 0, and no search is active.
- R2: A search starts only on a cycle where `search_trig` is 1 and was 0 on the previous cycle. That cycle's word does not count toward lock. A trigger held high does not start another search, and without a rising edge the block never locks.
- R3: The window is {current word, previous valid word}, with the previous word in bits 19:0. Offset k is the candidate at window bits k+19:k, for k in 0..19. A candidate matches when it equals `cfg_pattern` on every bit where `cfg_mask` is 1; mask bits at 0 are not compared.
- R4: When `cfg_inv_en` is 1, a candidate equal to the bitwise inverse of `cfg_pattern` on the unmasked bits also matches. When it is 0, the inverse does not match.
- R5: When `cfg_seq_en` is 1, offset k hits only if the previous valid word matched the pattern at k and the current candidate at k equals `cfg_seq_word` on the unmasked bits. The sequence word is never inverted.
- R6: While searching, a valid word that hits at the current candidate offset adds one to the lock count. A word that hits only elsewhere restarts the count at 1 on the lowest hitting offset. Words with no hit change nothing. Lock is declared on the word that brings the count to `cfg_lock_thr`; a value of 0 acts as 1.
- R7: While locked, `offset` does not change and `search_trig` has no effect.
- R8: While locked, each valid word is classified by `cfg_loss_mode`. In mode 0 and mode 3, a word is bad if it hits somewhere but not at the locked offset, good if it hits at the locked offset, and neutral if it hits nowhere. In mode 1, a word is bad when `dec_err` is 1 and good otherwise. In mode 2, a word is bad when `dec_err` or `disp_err` is 1 and good otherwise. Each bad word adds one to the unlock tally and clears the good run. When the tally reaches `cfg_unlock_thr`, lock drops and the block idles until the next rising trigger edge.
- R9: Each good word extends a good run. When the run reaches `cfg_dec_thr`, the run clears and the unlock tally drops by one, but not below 0.
- R10: `out_valid` follows `in_valid` one cycle later. `out_data` is the 20-bit window slice at the offset in force for that word; on the word that declares lock, this is the new offset. `offset` changes only when lock is declared and keeps its value after lock drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 20 | Raw deserialized word |
| in_valid | input | 1 | `in_data` is valid this cycle |
| cfg_pattern | input | 20 | Alignment word |
| cfg_mask | input | 20 | Compare mask, 1 means the bit is compared |
| cfg_inv_en | input | 1 | Also accept the inverted alignment word |
| cfg_seq_word | input | 20 | Trailing sequence word |
| cfg_seq_en | input | 1 | Require the trailing sequence word |
| cfg_lock_thr | input | 4 | Hits needed to declare lock |
| cfg_unlock_thr | input | 4 | Bad words needed to drop lock |
| cfg_dec_thr | input | 4 | Good words per tally decrement |
| cfg_loss_mode | input | 2 | 0/3 misalign, 1 decode error, 2 decode or disparity |
| dec_err | input | 1 | Decode error for the current word |
| disp_err | input | 1 | Disparity error for the current word |
| search_trig | input | 1 | Search request, acts on its rising edge |
| out_data | output | 20 | Realigned word |
| out_valid | output | 1 | `out_data` is valid |
| locked | output | 1 | Alignment declared |
| offset | output | 5 | Locked bit offset |

## Verification
The bench checks the exact lock word. A design that counted the trigger cycle, or that locked one word early or late, would show `locked` on the wrong cycle. Streams are placed at offsets that straddle the word boundary, so a reversed window order or a wrong slice base would report the wrong offset or data. Masked bits are flipped, the pattern is sent inverted, and the stream carries the pattern without its trailing word; a design that ignored the mask, the inverse enable or the sequence requirement would lock when it should not, or fail to lock when it should. In the loss tests, errors and good runs are interleaved so that a design without the decrement drops lock one word early. A disparity error in decode-only mode and a trigger held high after loss must both leave the state unchanged.

// File: rtl/sa_pkg.sv
package sa_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SEARCH = 2'd1,
      ST_LOCKED = 2'd2
   } sa_state_e;

   typedef enum logic [1:0] {
      LOSS_MISALIGN = 2'd0,
      LOSS_DECODE   = 2'd1,
      LOSS_DEC_DISP = 2'd2,
      LOSS_ALT      = 2'd3
   } sa_loss_e;
endpackage

// File: rtl/sa_match.sv
// Parallel offset comparator: one pattern and one sequence compare per offset.
module sa_match #(
   parameter int W       = 20,
   parameter bit HAS_SEQ = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic [2*W-1:0] window,
   input  logic [W-1:0]   pattern,
   input  logic [W-1:0]   mask,
   input  logic           inv_en,
   input  logic [W-1:0]   seq_word,
   input  logic           seq_en,
   output logic [W-1:0]   hit
);
   logic [W-1:0] pat_hit;
   logic [W-1:0] seq_hit;

   for (genvar k = 0; k < W; k++) begin : g_off
      logic [W-1:0] cand;
      assign cand = window[k +: W];
      assign pat_hit[k] = (((cand ^ pattern) & mask) == '0) ||
                          (inv_en && (((cand ^ ~pattern) & mask) == '0));
      assign seq_hit[k] = (((cand ^ seq_word) & mask) == '0);
   end

   if (HAS_SEQ) begin : g_seq
      logic [W-1:0] pat_hit_q;
      always_ff @(posedge clk) begin
         if (!rst_n)        pat_hit_q <= '0;
         else if (in_valid) pat_hit_q <= pat_hit;
      end
      assign hit = seq_en ? (pat_hit_q & seq_hit) : pat_hit;
   end else begin : g_noseq
      logic unused_seq;
      assign unused_seq = seq_en ^ (|seq_hit);
      assign hit = pat_hit;
   end
endmodule

// File: rtl/sa_lock_ctrl.sv
// Search / lock / loss state machine with lock, unlock and decrement counters.
module sa_lock_ctrl
   import sa_pkg::*;
#(
   parameter int W  = 20,
   parameter int CW = 4,
   localparam int OW = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [W-1:0]  hit,
   input  logic          trig,
   input  logic [CW-1:0] lock_thr,
   input  logic [CW-1:0] unlock_thr,
   input  logic [CW-1:0] dec_thr,
   input  logic [1:0]    loss_mode,
   input  logic          dec_err,
   input  logic          disp_err,
   output logic          locked,
   output logic [OW-1:0] offset,
   output logic [OW-1:0] offset_nxt
);
   sa_state_e     state_q, state_n;
   logic [CW-1:0] cnt_q, cnt_n, tally_q, tally_n, good_q, good_n;
   logic [OW-1:0] cand_q, cand_n, off_q, off_n, first;
   logic          trig_q, rise, bad, good;

   assign rise = trig & ~trig_q;

   always_comb begin
      first = '0;
      for (int k = W - 1; k >= 0; k--)
         if (hit[k]) first = k[OW-1:0];
   end

   always_comb begin
      unique case (sa_loss_e'(loss_mode))
         LOSS_DECODE: begin
            bad  = dec_err;
            good = !dec_err;
         end
         LOSS_DEC_DISP: begin
            bad  = dec_err | disp_err;
            good = !(dec_err | disp_err);
         end
         default: begin
            bad  = (|hit) && !hit[off_q];
            good = hit[off_q];
         end
      endcase
   end

   always_comb begin
      state_n = state_q;
      cnt_n   = cnt_q;
      cand_n  = cand_q;
      off_n   = off_q;
      tally_n = tally_q;
      good_n  = good_q;
      unique case (state_q)
         ST_IDLE: begin
            if (rise) begin
               state_n = ST_SEARCH;
               cnt_n   = '0;
            end
         end
         ST_SEARCH: begin
            if (rise) begin
               cnt_n = '0;
            end else if (in_valid && (|hit)) begin
               if (cnt_q != '0 && hit[cand_q]) begin
                  cnt_n = cnt_q + 1'b1;
               end else begin
                  cand_n = first;
                  cnt_n  = {{(CW-1){1'b0}}, 1'b1};
               end
               if (cnt_n >= lock_thr) begin
                  state_n = ST_LOCKED;
                  off_n   = cand_n;
                  tally_n = '0;
                  good_n  = '0;
               end
            end
         end
         ST_LOCKED: begin
            if (in_valid) begin
               if (bad) begin
                  tally_n = tally_q + 1'b1;
                  good_n  = '0;
                  if (tally_n >= unlock_thr) state_n = ST_IDLE;
               end else if (good) begin
                  good_n = good_q + 1'b1;
                  if (good_n >= dec_thr) begin
                     good_n = '0;
                     if (tally_q != '0) tally_n = tally_q - 1'b1;
                  end
               end
            end
         end
         default: state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         cand_q  <= '0;
         off_q   <= '0;
         tally_q <= '0;
         good_q  <= '0;
         trig_q  <= 1'b0;
      end else begin
         state_q <= state_n;
         cnt_q   <= cnt_n;
         cand_q  <= cand_n;
         off_q   <= off_n;
         tally_q <= tally_n;
         good_q  <= good_n;
         trig_q  <= trig;
      end
   end

   assign locked     = (state_q == ST_LOCKED);
   assign offset     = off_q;
   assign offset_nxt = off_n;
endmodule

// File: rtl/sa_slicer.sv
// Registered realignment: selects W bits of the window at the chosen offset.
module sa_slicer #(
   parameter int W  = 20,
   localparam int OW = $clog2(W)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic [2*W-1:0] window,
   input  logic [OW-1:0]  sel,
   output logic [W-1:0]   out_data,
   output logic           out_valid
);
   logic [2*W-1:0] shifted;
   assign shifted = window >> sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_data  <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= shifted[W-1:0];
      end
   end
endmodule

// File: rtl/symbol_aligner.sv
module symbol_aligner #(
   parameter int W       = 20,
   parameter int CW      = 4,
   parameter bit HAS_SEQ = 1'b1,
   localparam int OW = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  in_data,
   input  logic          in_valid,
   input  logic [W-1:0]  cfg_pattern,
   input  logic [W-1:0]  cfg_mask,
   input  logic          cfg_inv_en,
   input  logic [W-1:0]  cfg_seq_word,
   input  logic          cfg_seq_en,
   input  logic [CW-1:0] cfg_lock_thr,
   input  logic [CW-1:0] cfg_unlock_thr,
   input  logic [CW-1:0] cfg_dec_thr,
   input  logic [1:0]    cfg_loss_mode,
   input  logic          dec_err,
   input  logic          disp_err,
   input  logic          search_trig,
   output logic [W-1:0]  out_data,
   output logic          out_valid,
   output logic          locked,
   output logic [OW-1:0] offset
);
   if (W < 2) begin : g_bad_w
      $error("symbol_aligner: W must be at least 2");
   end
   if (CW < 1) begin : g_bad_cw
      $error("symbol_aligner: CW must be at least 1");
   end

   logic [W-1:0]   prev_q;
   logic [2*W-1:0] window;
   logic [W-1:0]   hit;
   logic [OW-1:0]  offset_nxt;

   always_ff @(posedge clk) begin
      if (!rst_n)        prev_q <= '0;
      else if (in_valid) prev_q <= in_data;
   end
   assign window = {in_data, prev_q};

   sa_match #(.W(W), .HAS_SEQ(HAS_SEQ)) u_match (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .window(window),
      .pattern(cfg_pattern), .mask(cfg_mask), .inv_en(cfg_inv_en),
      .seq_word(cfg_seq_word), .seq_en(cfg_seq_en), .hit(hit)
   );

   sa_lock_ctrl #(.W(W), .CW(CW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hit(hit),
      .trig(search_trig), .lock_thr(cfg_lock_thr), .unlock_thr(cfg_unlock_thr),
      .dec_thr(cfg_dec_thr), .loss_mode(cfg_loss_mode), .dec_err(dec_err),
      .disp_err(disp_err), .locked(locked), .offset(offset),
      .offset_nxt(offset_nxt)
   );

   sa_slicer #(.W(W)) u_slice (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .window(window),
      .sel(offset_nxt), .out_data(out_data), .out_valid(out_valid)
   );
endmodule

// File: rtl/sa_checker.sv
module sa_checker #(
   parameter int W = 20,
   localparam int OW = $clog2(W)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          out_valid,
   input logic          locked,
   input logic [OW-1:0] offset
);
   p_lock_on_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(in_valid));

   p_offset_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && $past(locked)) |-> $stable(offset));

   p_loss_on_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> $past(in_valid));

   p_offset_moves_at_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(offset) |-> $rose(locked));

   p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_valid_has_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));
endmodule

bind symbol_aligner sa_checker #(.W(W)) u_sa_checker (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
   .locked(locked), .offset(offset)
);

// File: tb/symbol_aligner_test.sv
module symbol_aligner_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] in_data = '0;
   logic        in_valid = 1'b0;
   logic [19:0] cfg_pattern = 20'h3C5A9;
   logic [19:0] cfg_mask = 20'hFFFFF;
   logic        cfg_inv_en = 1'b0;
   logic [19:0] cfg_seq_word = 20'hA0F36;
   logic        cfg_seq_en = 1'b0;
   logic [3:0]  cfg_lock_thr = 4'd3;
   logic [3:0]  cfg_unlock_thr = 4'd4;
   logic [3:0]  cfg_dec_thr = 4'd15;
   logic [1:0]  cfg_loss_mode = 2'd0;
   logic        dec_err = 1'b0;
   logic        disp_err = 1'b0;
   logic        search_trig = 1'b0;
   logic [19:0] out_data;
   logic        out_valid;
   logic        locked;
   logic [4:0]  offset;

   always #5 clk = ~clk;

   symbol_aligner uut (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
      .cfg_pattern(cfg_pattern), .cfg_mask(cfg_mask), .cfg_inv_en(cfg_inv_en),
      .cfg_seq_word(cfg_seq_word), .cfg_seq_en(cfg_seq_en),
      .cfg_lock_thr(cfg_lock_thr), .cfg_unlock_thr(cfg_unlock_thr),
      .cfg_dec_thr(cfg_dec_thr), .cfg_loss_mode(cfg_loss_mode),
      .dec_err(dec_err), .disp_err(disp_err), .search_trig(search_trig),
      .out_data(out_data), .out_valid(out_valid), .locked(locked), .offset(offset)
   );

   int checks = 0;
   int fails = 0;
   int wn = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   int          m_state, m_cand, m_cnt, m_tally, m_good, m_off, m_offn, m_first;
   bit          m_trig_q, m_rise, m_bad, m_goodw;
   logic [19:0] m_prev, m_cand_w, e_out;
   logic [39:0] m_win, m_sh;
   bit   [19:0] m_phit, m_ph, m_hv;
   bit          e_ov, e_locked;
   int          e_off;
   int          lthr, uthr, dthr;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_cand = 0; m_cnt = 0; m_tally = 0; m_good = 0; m_off = 0;
         m_trig_q = 0; m_prev = '0; m_phit = '0;
         e_out = '0; e_ov = 0; e_locked = 0; e_off = 0;
      end else begin
         m_win = {in_data, m_prev};
         for (int k = 0; k < 20; k++) begin
            m_cand_w = m_win[k +: 20];
            m_ph[k] = (((m_cand_w ^ cfg_pattern) & cfg_mask) == 0) ||
                      (cfg_inv_en && (((~m_cand_w) ^ cfg_pattern) & cfg_mask) == 0);
            m_hv[k] = cfg_seq_en ? (m_phit[k] && (((m_cand_w ^ cfg_seq_word) & cfg_mask) == 0))
                                 : m_ph[k];
         end
         m_first = -1;
         for (int k = 0; k < 20; k++) if (m_hv[k] && m_first < 0) m_first = k;
         lthr = (cfg_lock_thr == 0) ? 1 : int'(cfg_lock_thr);
         uthr = int'(cfg_unlock_thr);
         dthr = int'(cfg_dec_thr);
         m_rise = search_trig && !m_trig_q;
         m_offn = m_off;
         if (m_state == 0) begin
            if (m_rise) begin m_state = 1; m_cnt = 0; end
         end else if (m_state == 1) begin
            if (m_rise) m_cnt = 0;
            else if (in_valid && m_first >= 0) begin
               if (m_cnt > 0 && m_hv[m_cand]) m_cnt++;
               else begin m_cand = m_first; m_cnt = 1; end
               if (m_cnt >= lthr) begin
                  m_state = 2; m_off = m_cand; m_offn = m_cand; m_tally = 0; m_good = 0;
               end
            end
         end else if (in_valid) begin
            case (cfg_loss_mode)
               2'd1: begin m_bad = dec_err; m_goodw = !dec_err; end
               2'd2: begin m_bad = dec_err || disp_err; m_goodw = !m_bad; end
               default: begin m_bad = (m_first >= 0) && !m_hv[m_off]; m_goodw = m_hv[m_off]; end
            endcase
            if (m_bad) begin
               m_tally++; m_good = 0;
               if (m_tally >= uthr) m_state = 0;
            end else if (m_goodw) begin
               m_good++;
               if (m_good >= dthr) begin m_good = 0; if (m_tally > 0) m_tally--; end
            end
         end
         if (in_valid) begin
            m_sh = m_win >> m_offn;
            e_out = m_sh[19:0];
            m_prev = in_data;
            m_phit = m_ph;
         end
         e_ov = in_valid;
         e_locked = (m_state == 2);
         e_off = m_off;
         m_trig_q = search_trig;
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(out_valid == e_ov, "R10 out_valid vs model", int'(out_valid), int'(e_ov));
         chk(locked == e_locked, "R6/R8 locked vs model", int'(locked), int'(e_locked));
         chk(int'(offset) == e_off, "R7 offset vs model", int'(offset), e_off);
         if (e_ov) chk(out_data == e_out, "R10 out_data vs model", int'(out_data), int'(e_out));
      end
   end

   // ---------------- stimulus helpers ----------------
   function automatic logic [19:0] mkw(int n, int p, logic [19:0] a, logic [19:0] b, bit alt);
      logic [19:0] r, s;
      int t;
      for (int i = 0; i < 20; i++) begin
         t = 20 * n + i - p + 400;
         s = (alt && ((t / 20) % 2 == 1)) ? b : a;
         r[i] = s[t % 20];
      end
      return r;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0; search_trig = 1'b0; dec_err = 1'b0; disp_err = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      wn = 0;
   endtask

   task automatic send(input logic [19:0] d, input bit de, input bit pe);
      @(negedge clk);
      in_valid = 1'b1; in_data = d; dec_err = de; disp_err = pe; search_trig = search_trig;
   endtask

   task automatic sym(input int p, input logic [19:0] a, input logic [19:0] b, input bit alt,
                      input bit de, input bit pe);
      send(mkw(wn, p, a, b, alt), de, pe);
      wn++;
   endtask

   task automatic gap();
      @(negedge clk);
      in_valid = 1'b0; dec_err = 1'b0; disp_err = 1'b0;
   endtask

   task automatic pulse();
      @(negedge clk);
      in_valid = 1'b0; search_trig = 1'b1;
      @(negedge clk);
      search_trig = 1'b0;
   endtask

   task automatic lock_at(input int p);
      pulse();
      for (int i = 0; i < 4; i++) sym(p, cfg_pattern, cfg_seq_word, 0, 0, 0);
      gap();
   endtask

   // ---------------- scenarios ----------------
   initial begin
      do_reset();
      @(negedge clk);
      chk(locked == 1'b0, "R1 reset locked", int'(locked), 0);
      chk(offset == 5'd0, "R1 reset offset", int'(offset), 0);
      chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);

      // R2: no trigger, no lock
      for (int i = 0; i < 6; i++) sym(7, cfg_pattern, cfg_seq_word, 0, 0, 0);
      gap();
      chk(locked == 1'b0, "R2 no lock without trigger edge", int'(locked), 0);

      // R6: lock on the third hit, R3 offset straddling the boundary
      pulse();
      sym(7, cfg_pattern, cfg_seq_word, 0, 0, 0);
      sym(7, cfg_pattern, cfg_seq_word, 0, 0, 0);
      gap();
      chk(locked == 1'b0, "R6 not locked after two hits", int'(locked), 0);
      sym(7, cfg_pattern, cfg_seq_word, 0, 0, 0);
      gap();
      chk(locked == 1'b1, "R6 locked after third hit", int'(locked), 1);
      chk(offset == 5'd7, "R3 locked offset", int'(offset), 7);
      chk(out_data == cfg_pattern, "R10 realigned data", int'(out_data), int'(cfg_pattern));

      // R7: trigger and foreign offset ignored while locked
      pulse();
      for (int i = 0; i < 3; i++) sym(12, cfg_pattern, cfg_seq_word, 0, 0, 0);
      for (int i = 0; i < 3; i++) sym(7, cfg_pattern, cfg_seq_word, 0, 0, 0);
      gap();
      chk(locked == 1'b1 && offset == 5'd7, "R7 offset frozen while locked", int'(offset), 7);

      // R8 misalign loss, R10 offset held after loss, relock elsewhere
      do_reset();
      lock_at(7);
      for (int i = 0; i < 8; i++) sym(12, cfg_pattern, cfg_seq_word, 0, 0, 0);
      gap();
      chk(locked == 1'b0, "R8 misalignment drops lock", int'(locked), 0);
      chk(offset == 5'd7, "R10 offset held after loss", int'(offset), 7);
      lock_at(12);
      chk(locked == 1'b1 && offset == 5'd12, "R6 relock at new offset", int'(offset), 12);

      // R3 mask
      do_reset();
      cfg_mask = 20'hFFF0F;
      pulse();
      for (int i = 0; i < 5; i++) sym(4, cfg_pattern ^ 20'h000A0, cfg_seq_word, 0, 0, 0);
      gap();
      chk(locked == 1'b1 && offset == 5'd4, "R3 masked bits ignored", int'(offset), 4);
      do_reset();
      cfg_mask = 20'hFFFFF;
      pulse();
      for (int i = 0; i < 5; i++) sym(4, cfg_pattern ^ 20'h000A0, cfg_seq_word, 0, 0, 0);
      gap();
      chk(locked == 1'b0, "R3 unmasked difference blocks match", int'(locked), 0);

      // R4 inverse
      do_reset();
      cfg_inv_en = 1'b1;
      pulse();
      for (int i = 0; i < 5; i++) sym(3, ~cfg_pattern, cfg_seq_word, 0, 0, 0);
      gap();
      chk(locked == 1'b1 && offset == 5'd3, "R4 inverse accepted", int'(offset), 3);
      do_reset();
      cfg_inv_en = 1'b0;
      pulse();
      for (int i = 0; i < 5; i++) sym(3, ~cfg_pattern, cfg_seq_word, 0, 0, 0);
      gap();
      chk(locked == 1'b0, "R4 inverse rejected when disabled", int'(locked), 0);

      // R5 trailing sequence
      do_reset();
      cfg_seq_en = 1'b1; cfg_lock_thr = 4'd2;
      pulse();
      for (int i = 0; i < 6; i++) sym(5, cfg_pattern, cfg_seq_word, 1, 0, 0);
      gap();
      chk(locked == 1'b1 && offset == 5'd5, "R5 pattern plus sequence locks", int'(offset), 5);
      do_reset();
      pulse();
      for (int i = 0; i < 8; i++) sym(5, cfg_pattern, cfg_seq_word, 0, 0, 0);
      gap();
      chk(locked == 1'b0, "R5 pattern without sequence", int'(locked), 0);
      cfg_seq_en = 1'b0; cfg_lock_thr = 4'd3;

      // R2 held trigger does not restart
      do_reset();
      cfg_loss_mode = 2'd1; cfg_unlock_thr = 4'd1;
      @(negedge clk);
      search_trig = 1'b1;
      for (int i = 0; i < 4; i++) sym(7, cfg_pattern, cfg_seq_word, 0, 0, 0);
      gap();
      chk(locked == 1'b1, "R2 lock from first edge", int'(locked), 1);
      sym(7, cfg_pattern, cfg_seq_word, 0, 1, 0);
      for (int i = 0; i < 6; i++) sym(7, cfg_pattern, cfg_seq_word, 0, 0, 0);
      gap();
      chk(locked == 1'b0, "R2 held trigger gives no new search", int'(locked), 0);
      search_trig = 1'b0;
      pulse();
      for (int i = 0; i < 3; i++) sym(7, cfg_pattern, cfg_seq_word, 0, 0, 0);
      gap();
      chk(locked == 1'b1, "R2 new edge relocks", int'(locked), 1);

      // R8 decode mode ignores disparity, R9 decrement
      do_reset();
      cfg_loss_mode = 2'd1; cfg_unlock_thr = 4'd3; cfg_dec_thr = 4'd2;
      lock_at(7);
      for (int i = 0; i < 3; i++) sym(7, cfg_pattern, cfg_seq_word, 0, 0, 1);
      gap();
      chk(locked == 1'b1, "R8 disparity ignored in decode mode", int'(locked), 1);
      sym(7, cfg_pattern, cfg_seq_word, 0, 1, 0);
      sym(7, cfg_pattern, cfg_seq_word, 0, 0, 0);
      sym(7, cfg_pattern, cfg_seq_word, 0, 0, 0);
      sym(7, cfg_pattern, cfg_seq_word, 0, 1, 0);
      sym(7, cfg_pattern, cfg_seq_word, 0, 1, 0);
      gap();
      chk(locked == 1'b1, "R9 good run lowered the tally", int'(locked), 1);
      sym(7, cfg_pattern, cfg_seq_word, 0, 1, 0);
      gap();
      chk(locked == 1'b0, "R8 decode errors reach threshold", int'(locked), 0);

      // R8 decode-or-disparity mode
      do_reset();
      cfg_loss_mode = 2'd2; cfg_unlock_thr = 4'd1; cfg_dec_thr = 4'd15;
      lock_at(7);
      sym(7, cfg_pattern, cfg_seq_word, 0, 0, 1);
      gap();
      chk(locked == 1'b0, "R8 disparity error drops lock in mode 2", int'(locked), 0);

      gap();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule